// File: doc/BRIEF.md
# Multi-Bit Boolean Configuration Validator

This block sits beside a bank of 4-bit configuration fields that use a sparse two-value encoding (0x6 means True, 0x9 means False). It turns each field into a single safe bit for downstream logic. A field holding any other pattern counts as a fault: it decodes to False and latches a sticky status bit. The same status word also latches a set of hardware fault events. Two of these events are detected inside the block. One is a repeat of a value on an internal data bus. The other is a firmware write into a full override buffer, which counts only while both override fields are True.

Software reads the status word through a simple register port and clears bits by writing zero to them. A recoverable-alert output pulses for one cycle whenever any status bit goes from 0 to 1.

The bus-repeat detector is a two-state machine. CMP_EMPTY holds no reference value. It is the reset state, and the first valid bus beat moves it to CMP_HOLD (transition "capture"). In CMP_HOLD every valid beat is compared with the stored value and then replaces it (transition "compare-and-replace"). The machine stays in CMP_HOLD until reset. Any illegal state code returns it to CMP_EMPTY.

Top module: `mubi_guard`

## Requirements
- R1: While reset is applied and right after it is released, the status word reads 0 and `alert_o` is low.
- R2: `dec_o[k]` is 1 only when field k (bits 4k+3..4k of `cfg_fields_i`) equals 0x6. The value 0x9 and every other pattern give 0.
- R3: One cycle after field k holds a value other than 0x6 or 0x9, a status bit is 1. Field k maps to status bit 0, 1, 2, 3, 5, 7, 8, 9, 10 and 11 for k = 0 to 9 respectively. A legal value never sets its bit.
- R4: Status bits 4, 6 and 31 down to 17 always read 0, even after writing all ones.
- R5: `sm_fail_i`, `thr_cfg_err_i` and `early_dis_i` set status bits 12, 14 and 16 respectively, one cycle later.
- R6: Bit 13 is set one cycle after a beat with `dbus_vld_i`=1 whose data equals the data of the previous valid beat. The first valid beat after reset never sets it, and cycles without valid do not change the stored reference.
- R7: Bit 15 is set one cycle after `fw_wr_i` and `fw_full_i` are both 1 while field 6 and field 7 both equal 0x6. In every other case bit 15 is not set.
- R8: A register write clears every status bit whose write-data bit is 0 and leaves bits written with 1 unchanged. The result is visible one cycle after the write.
- R9: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up 1.
- R10: `alert_o` is 1 in exactly the cycle in which at least one status bit has newly become 1 (one cycle after the cause). A condition that keeps an already-set bit at 1 gives no new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_fields_i | input | 40 | Ten 4-bit encoded fields, field k in bits 4k+3..4k |
| sm_fail_i | input | 1 | Main controller threshold failure event |
| thr_cfg_err_i | input | 1 | Threshold configuration error event |
| early_dis_i | input | 1 | Override disabled too early event |
| dbus_vld_i | input | 1 | Internal data bus beat valid |
| dbus_data_i | input | DW (32) | Internal data bus value |
| fw_wr_i | input | 1 | Firmware writes the override buffer |
| fw_full_i | input | 1 | Override buffer is full |
| reg_we_i | input | 1 | Write strobe for the status word |
| reg_wdata_i | input | 32 | Write data: a 0 clears a bit, a 1 keeps it |
| reg_rdata_o | output | 32 | Status word |
| dec_o | output | 10 | Decoded field booleans |
| alert_o | output | 1 | One-cycle recoverable alert pulse |

## Verification
The collision of interest is a hardware set and a software clear landing on the same status bit in one cycle. The bench provokes it twice. Once, a malformed field and a zero write hit a bit that was clear. Once, an event and a zero write hit a bit already set. The bench expects the bit to read 1 afterwards. It expects an alert pulse only in the first case.

// File: rtl/mubi_guard_pkg.sv
package mubi_guard_pkg;

    localparam int NFLD = 10;
    localparam int FW   = 4;
    localparam int SW   = 32;

    localparam logic [FW-1:0] MB_TRUE  = 4'h6;
    localparam logic [FW-1:0] MB_FALSE = 4'h9;

    localparam int F_OVR_MODE = 6;
    localparam int F_OVR_INS  = 7;

    localparam int B_SM_FAIL = 12;
    localparam int B_BUS_REP = 13;
    localparam int B_THR_CFG = 14;
    localparam int B_WR_FULL = 15;
    localparam int B_EARLY   = 16;

    typedef enum logic [1:0] {
        CMP_EMPTY = 2'b01,
        CMP_HOLD  = 2'b10
    } cmp_state_e;

    function automatic int fld_pos(input int k);
        if (k < 4)       return k;
        else if (k == 4) return 5;
        else             return k + 2;
    endfunction

    function automatic logic [SW-1:0] stat_mask();
        logic [SW-1:0] m;
        m = '0;
        for (int k = 0; k < NFLD; k++) m[fld_pos(k)] = 1'b1;
        for (int b = B_SM_FAIL; b <= B_EARLY; b++) m[b] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/mubi_field_check.sv
module mubi_field_check
    import mubi_guard_pkg::*;
(
    input  logic [NFLD*FW-1:0] fields_i,
    output logic [NFLD-1:0]    true_o,
    output logic [NFLD-1:0]    bad_o
);

    for (genvar k = 0; k < NFLD; k++) begin : g_fld
        logic [FW-1:0] val;
        assign val       = fields_i[k*FW +: FW];
        assign true_o[k] = (val == MB_TRUE);
        assign bad_o[k]  = (val != MB_TRUE) && (val != MB_FALSE);
    end

endmodule

// File: rtl/bus_repeat_det.sv
module bus_repeat_det
    import mubi_guard_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          vld_i,
    input  logic [DW-1:0] data_i,
    output logic          repeat_o
);

    cmp_state_e    state_q, state_d;
    logic [DW-1:0] prev_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CMP_EMPTY;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            if (vld_i) prev_q <= data_i;
        end
    end

    // next state and output
    always_comb begin
        state_d  = state_q;
        repeat_o = 1'b0;
        unique case (state_q)
            CMP_EMPTY: begin
                if (vld_i) state_d = CMP_HOLD;
            end
            CMP_HOLD: begin
                repeat_o = vld_i && (data_i == prev_q);
            end
            default: state_d = CMP_EMPTY;
        endcase
    end

endmodule

// File: rtl/status_bank.sv
module status_bank
    import mubi_guard_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [SW-1:0] set_i,
    input  logic          we_i,
    input  logic [SW-1:0] wdata_i,
    output logic [SW-1:0] stat_o,
    output logic          alert_o
);

    localparam logic [SW-1:0] MASK = stat_mask();

    logic [SW-1:0] stat_q, stat_d, keep;
    logic          alert_q;

    always_comb begin
        keep   = we_i ? wdata_i : '1;
        stat_d = ((stat_q & keep) | set_i) & MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q  <= '0;
            alert_q <= 1'b0;
        end else begin
            stat_q  <= stat_d;
            alert_q <= |(stat_d & ~stat_q);
        end
    end

    assign stat_o  = stat_q;
    assign alert_o = alert_q;

endmodule

// File: rtl/mubi_guard.sv
module mubi_guard
    import mubi_guard_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NFLD*FW-1:0] cfg_fields_i,
    input  logic               sm_fail_i,
    input  logic               thr_cfg_err_i,
    input  logic               early_dis_i,
    input  logic               dbus_vld_i,
    input  logic [DW-1:0]      dbus_data_i,
    input  logic               fw_wr_i,
    input  logic               fw_full_i,
    input  logic               reg_we_i,
    input  logic [SW-1:0]      reg_wdata_i,
    output logic [SW-1:0]      reg_rdata_o,
    output logic [NFLD-1:0]    dec_o,
    output logic               alert_o
);

    logic [NFLD-1:0] fld_true, fld_bad;
    logic            bus_rep;
    logic [SW-1:0]   hw_set;

    mubi_field_check u_fld (
        .fields_i (cfg_fields_i),
        .true_o   (fld_true),
        .bad_o    (fld_bad)
    );

    bus_repeat_det #(.DW(DW)) u_rep (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .vld_i    (dbus_vld_i),
        .data_i   (dbus_data_i),
        .repeat_o (bus_rep)
    );

    always_comb begin
        hw_set = '0;
        for (int k = 0; k < NFLD; k++) hw_set[fld_pos(k)] = fld_bad[k];
        hw_set[B_SM_FAIL] = sm_fail_i;
        hw_set[B_BUS_REP] = bus_rep;
        hw_set[B_THR_CFG] = thr_cfg_err_i;
        hw_set[B_WR_FULL] = fw_wr_i && fw_full_i
                            && fld_true[F_OVR_MODE] && fld_true[F_OVR_INS];
        hw_set[B_EARLY]   = early_dis_i;
    end

    status_bank u_stat (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (hw_set),
        .we_i    (reg_we_i),
        .wdata_i (reg_wdata_i),
        .stat_o  (reg_rdata_o),
        .alert_o (alert_o)
    );

    assign dec_o = fld_true;

endmodule

// File: rtl/mubi_guard_chk.sv
module mubi_guard_chk
    import mubi_guard_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NFLD*FW-1:0] cfg_fields_i,
    input logic               sm_fail_i,
    input logic               fw_wr_i,
    input logic               fw_full_i,
    input logic               reg_we_i,
    input logic [SW-1:0]      reg_wdata_i,
    input logic [SW-1:0]      reg_rdata_o,
    input logic [NFLD-1:0]    dec_o,
    input logic               alert_o
);

    p_dec_true_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_o[0] |-> (cfg_fields_i[3:0] == 4'h6));

    p_bad_field_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_fields_i[3:0] != 4'h6 && cfg_fields_i[3:0] != 4'h9) |=> reg_rdata_o[0]);

    p_rsvd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rdata_o[4] == 1'b0) && (reg_rdata_o[6] == 1'b0) && (reg_rdata_o[31:17] == '0));

    p_wfull_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rdata_o[15] && !$past(reg_rdata_o[15])) |->
        $past(fw_wr_i && fw_full_i && cfg_fields_i[27:24] == 4'h6 && cfg_fields_i[31:28] == 4'h6));

    p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((reg_rdata_o & $past(reg_rdata_o & (reg_we_i ? reg_wdata_i : '1)))
                  == $past(reg_rdata_o & (reg_we_i ? reg_wdata_i : '1))));

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sm_fail_i |=> reg_rdata_o[12]);

    p_alert_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alert_o |-> ((reg_rdata_o & ~$past(reg_rdata_o)) != '0));

endmodule

bind mubi_guard mubi_guard_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_fields_i (cfg_fields_i),
    .sm_fail_i    (sm_fail_i),
    .fw_wr_i      (fw_wr_i),
    .fw_full_i    (fw_full_i),
    .reg_we_i     (reg_we_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .dec_o        (dec_o),
    .alert_o      (alert_o)
);

// File: tb/tb_mubi_guard.sv
`timescale 1ns/1ps
module tb_mubi_guard;

    localparam logic [39:0] F9 = {10{4'h9}};
    localparam logic [39:0] F6 = {10{4'h6}};
    localparam int POS [10] = '{0, 1, 2, 3, 5, 7, 8, 9, 10, 11};

    typedef struct {
        string       tag;
        logic [31:0] rd;
        logic        al;
        logic [9:0]  dec;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] fields = F9;
    logic        sm = 0, tc = 0, ed = 0, bv = 0, wr = 0, full = 0, we = 0;
    logic [31:0] bd = '0, wd = '0;
    logic [31:0] rdata;
    logic [9:0]  dec;
    logic        alert;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    exp_t        q[$];
    logic [31:0] m_stat = '0;
    logic [31:0] m_prev = '0;
    bit          m_have = 0;

    always #2.5 clk = ~clk;

    mubi_guard dut (
        .clk_i (clk), .rst_ni (rst_n), .cfg_fields_i (fields),
        .sm_fail_i (sm), .thr_cfg_err_i (tc), .early_dis_i (ed),
        .dbus_vld_i (bv), .dbus_data_i (bd), .fw_wr_i (wr), .fw_full_i (full),
        .reg_we_i (we), .reg_wdata_i (wd), .reg_rdata_o (rdata),
        .dec_o (dec), .alert_o (alert)
    );

    function automatic logic [39:0] setf(input logic [39:0] b, input int k, input logic [3:0] v);
        logic [39:0] r;
        r = b;
        r[4*k +: 4] = v;
        return r;
    endfunction

    // driver: apply one cycle of stimulus and push the expected result
    task automatic step(input logic [39:0] f, input logic i_sm, i_tc, i_ed,
                        input logic i_bv, input logic [31:0] i_bd,
                        input logic i_wr, i_full, input logic i_we,
                        input logic [31:0] i_wd, input string tag);
        exp_t        e;
        logic [31:0] set, nxt, keep;
        logic [9:0]  d;
        @(negedge clk);
        fields = f; sm = i_sm; tc = i_tc; ed = i_ed; bv = i_bv; bd = i_bd;
        wr = i_wr; full = i_full; we = i_we; wd = i_wd;
        set = '0; d = '0;
        for (int k = 0; k < 10; k++) begin
            if (f[4*k +: 4] == 4'h6) d[k] = 1'b1;
            else if (f[4*k +: 4] != 4'h9) set[POS[k]] = 1'b1;
        end
        if (i_sm) set[12] = 1'b1;
        if (i_tc) set[14] = 1'b1;
        if (i_ed) set[16] = 1'b1;
        if (i_bv) begin
            if (m_have && i_bd == m_prev) set[13] = 1'b1;
            m_prev = i_bd;
            m_have = 1;
        end
        if (i_wr && i_full && f[27:24] == 4'h6 && f[31:28] == 4'h6) set[15] = 1'b1;
        keep = i_we ? i_wd : 32'hFFFF_FFFF;
        nxt = (m_stat & keep) | set;
        e.tag = tag; e.rd = nxt; e.al = |(nxt & ~m_stat); e.dec = d;
        m_stat = nxt;
        q.push_back(e);
    endtask

    task automatic idle_fields(input logic [39:0] f, input string tag);
        step(f, 0, 0, 0, 0, '0, 0, 0, 0, '0, tag);
    endtask

    task automatic clear_all(input string tag);
        step(F9, 0, 0, 0, 0, '0, 0, 0, 1, 32'h0, tag);
    endtask

    // monitor: compare one expected item per cycle, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (rdata !== e.rd || alert !== e.al || dec !== e.dec) begin
                    errors++;
                    $display("FAIL %s: rdata=%h alert=%b dec=%b, expected rdata=%h alert=%b dec=%b",
                             e.tag, rdata, alert, dec, e.rd, e.al, e.dec);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rdata !== 32'h0 || alert !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: rdata=%h alert=%b, expected 0 0", rdata, alert);
        end
        rst_n = 1'b1;

        idle_fields(F9, "R1 R2 all False after reset");
        idle_fields(F6, "R2 all True decode");
        idle_fields(setf(F6, 0, 4'h0), "R3 field0 malformed");
        idle_fields(setf(F6, 0, 4'h0), "R10 no second pulse");
        for (int k = 1; k < 10; k++)
            idle_fields(setf(F9, k, (k % 2) ? 4'hF : 4'h7), "R3 field malformed");
        clear_all("R8 clear all by zero write");

        step(setf(F9, 4, 4'h1), 0, 0, 0, 0, '0, 0, 0, 1, 32'h0, "R9 set beats clear, fresh bit");
        step(F9, 0, 0, 0, 0, '0, 0, 0, 1, 32'hFFFF_FFFF, "R8 write ones keeps");
        step(F9, 0, 0, 0, 0, '0, 0, 0, 1, ~32'h20, "R8 zero clears its bit");

        step(F9, 1, 0, 0, 0, '0, 0, 0, 0, '0, "R5 sm fail bit12");
        step(F9, 0, 1, 1, 0, '0, 0, 0, 0, '0, "R5 bits 14 and 16");
        step(F9, 1, 0, 0, 0, '0, 0, 0, 1, 32'h0, "R9 set beats clear, held bit");
        clear_all("R8 clear events");

        step(F9, 0, 0, 0, 1, 32'hA5A5_0001, 0, 0, 0, '0, "R6 first beat no flag");
        step(F9, 0, 0, 0, 1, 32'h3C3C_0002, 0, 0, 0, '0, "R6 new value no flag");
        step(F9, 0, 0, 0, 0, 32'h1111_1111, 0, 0, 0, '0, "R6 invalid beat ignored");
        step(F9, 0, 0, 0, 1, 32'h3C3C_0002, 0, 0, 0, '0, "R6 repeat flags bit13");
        step(F9, 0, 0, 0, 1, 32'h3C3C_0002, 0, 0, 0, '0, "R10 repeat again no pulse");
        clear_all("R8 clear repeat");

        step(F9, 0, 0, 0, 0, '0, 1, 1, 0, '0, "R7 overrides False");
        step(setf(F9, 6, 4'h6), 0, 0, 0, 0, '0, 1, 1, 0, '0, "R7 only mode True");
        step(setf(F9, 7, 4'h6), 0, 0, 0, 0, '0, 1, 1, 0, '0, "R7 only insert True");
        step(setf(setf(F9, 6, 4'h6), 7, 4'h6), 0, 0, 0, 0, '0, 1, 0, 0, '0, "R7 not full");
        step(setf(setf(F9, 6, 4'hE), 7, 4'h6), 0, 0, 0, 0, '0, 1, 1, 0, '0, "R7 malformed mode");
        step(setf(setf(F9, 6, 4'h6), 7, 4'h6), 0, 0, 0, 0, '0, 1, 1, 0, '0, "R7 write while full");
        clear_all("R8 clear override");

        step({10{4'h0}}, 1, 1, 1, 0, '0, 0, 0, 0, '0, "R4 set every bit");
        step(F9, 0, 0, 0, 0, '0, 0, 0, 1, 32'hFFFF_FFFF, "R4 reserved stay zero");
        clear_all("R8 final clear");

        idle_fields(F9, "R1 quiet tail");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule